// File: doc/BRIEF.md
# Quadrature Encoder Decoder

This block turns the two phase signals and the index signal of an incremental rotary encoder into a position count, a direction flag and a velocity figure. Both phases and the index line are first passed through a two-flop synchronizer. A four-state phase tracker then sorts each new sample into one of four cases: a forward step, a reverse step, no change, or an illegal jump. Every legal Gray-code transition moves the position by one, which gives four counts per encoder line. Phase changes may arrive as often as once every four system clocks.

A programmable down-counting window timer measures speed. The block counts legal steps of either direction while the window is open. When the timer reaches zero, the count is copied to the velocity output, the count is cleared and the timer reloads. Four sticky event flags record index rising edges, window expiries, direction reversals and quadrature errors. A mask combines them into one interrupt line. Software loads position, maximum position, window period and mask, and clears flags, through a simple write-only register port.

Phase tracker states are named by the last synchronized `{a,b}` code: `PH_00`, `PH_10`, `PH_11`, `PH_01`. The forward transitions are PH_00→PH_10→PH_11→PH_01→PH_00, and the reverse transitions run the other way round the ring. The diagonal transitions (PH_00↔PH_11, PH_10↔PH_01) are errors. In every case the tracker moves to the state of the new sample.

Top module: `qenc_core`

## Requirements
- R1: The phase inputs go through two synchronizer flops. A phase change driven just after a rising edge leaves `position` unchanged after the second rising edge and updates it on the third.
- R2: With phase code `{ph_a,ph_b}`, the sequence 00→10→11→01→00 adds one to `position` per transition, and the opposite order subtracts one. At most one of forward step, reverse step or error occurs in a cycle.
- R3: A forward step taken while `position` equals the maximum-position register sets `position` to 0.
- R4: A reverse step taken while `position` is 0 sets `position` to the maximum-position register value.
- R5: A sample in which both phases change at once leaves `position` and `dir_fwd` unchanged and sets `irq_status[3]`.
- R6: `dir_fwd` is 1 after a forward step and 0 after a reverse step. A step opposite to the current `dir_fwd` sets `irq_status[2]`.
- R7: A rising edge on the synchronized index input sets `irq_status[0]`.
- R8: The window timer counts down once per clock from the period value. In the cycle it is 0, it latches the number of steps seen in the window (period+1 cycles) into `velocity`, clears the step count, reloads the period and sets `irq_status[1]`. Writing the period (address 2) reloads the timer and clears the count.
- R9: Each `irq_status` bit stays set until a write to address 4 with a 1 in that bit position of `reg_wdata`. Bits written 0 are kept.
- R10: `irq` is high exactly when some `irq_status` bit is set whose mask bit (address 3, bits 3:0) is also set.
- R11: A write to address 0 loads `position` and takes priority over a step in the same cycle. A write to address 1 loads the maximum position.
- R12: After reset: `position` 0, `velocity` 0, `dir_fwd` 1, `irq_status` 0, mask 0 (so `irq` 0), maximum position all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ph_a | input | 1 | Encoder phase A (asynchronous) |
| ph_b | input | 1 | Encoder phase B (asynchronous) |
| idx_in | input | 1 | Encoder index pulse (asynchronous) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 position, 1 max position, 2 period, 3 mask, 4 flag clear |
| reg_wdata | input | REG_W | Register write data |
| position | output | POS_W | Position integrator |
| velocity | output | VEL_W | Steps counted in the last completed window |
| dir_fwd | output | 1 | 1 when the last step was forward |
| irq_status | output | 4 | Sticky flags: 0 index, 1 window expiry, 2 reversal, 3 phase error |
| irq | output | 1 | Masked OR of the flags |

## Verification
On every cycle, the assertions check that the step classes exclude one another and that both wrap directions land on the right value. They also check that errors freeze the position, that reversals and window expiries raise their flags, and that no set flag is lost unless a clear write names it. Only the bench scenarios can show the synchronizer latency and the absolute step counts over forward, reverse and wrapping runs. The same holds for the velocity figure produced over a whole window, for index capture through the synchronizer, and for the mask combining flags into `irq`.

// File: rtl/qenc_pkg.sv
`timescale 1ns/1ps
package qenc_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_POS  = 3'd0;
    localparam logic [ADDR_W-1:0] A_MAX  = 3'd1;
    localparam logic [ADDR_W-1:0] A_PER  = 3'd2;
    localparam logic [ADDR_W-1:0] A_MASK = 3'd3;
    localparam logic [ADDR_W-1:0] A_CLR  = 3'd4;

    localparam int IRQ_N    = 4;
    localparam int IRQ_IDX  = 0;
    localparam int IRQ_WIN  = 1;
    localparam int IRQ_DIR  = 2;
    localparam int IRQ_QERR = 3;

    // state name carries the last synchronized {a,b} code
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_10 = 2'b10,
        PH_11 = 2'b11
    } phase_e;
endpackage

// File: rtl/qenc_sync.sv
`timescale 1ns/1ps
module qenc_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/qenc_decode.sv
`timescale 1ns/1ps
module qenc_decode
    import qenc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ab,
    output logic       fwd,
    output logic       rev,
    output logic       err
);
    phase_e state;
    phase_e nxt_f;
    phase_e nxt_r;

    // state register: always follows the newest sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PH_00;
        else        state <= phase_e'(ab);
    end

    // outputs: classify the sample against the ring neighbours
    always_comb begin
        nxt_f = PH_00;
        nxt_r = PH_00;
        unique case (state)
            PH_00: begin nxt_f = PH_10; nxt_r = PH_01; end
            PH_10: begin nxt_f = PH_11; nxt_r = PH_00; end
            PH_11: begin nxt_f = PH_01; nxt_r = PH_10; end
            PH_01: begin nxt_f = PH_00; nxt_r = PH_11; end
        endcase
        fwd = (ab == nxt_f);
        rev = (ab == nxt_r);
        err = (ab == ~state);
    end
endmodule

// File: rtl/qenc_pos.sv
`timescale 1ns/1ps
module qenc_pos #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fwd,
    input  logic         rev,
    input  logic         pos_wr,
    input  logic         max_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] pos,
    output logic [W-1:0] max_q,
    output logic         dir_fwd,
    output logic         dir_chg
);
    logic [W-1:0] pos_up;
    logic [W-1:0] pos_dn;

    assign pos_up  = (pos == max_q) ? '0 : pos + 1'b1;
    assign pos_dn  = (pos == '0) ? max_q : pos - 1'b1;
    assign dir_chg = (fwd && !dir_fwd) || (rev && dir_fwd);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos     <= '0;
            max_q   <= '1;
            dir_fwd <= 1'b1;
        end else begin
            if (pos_wr)   pos <= wdata;
            else if (fwd) pos <= pos_up;
            else if (rev) pos <= pos_dn;

            if (max_wr) max_q <= wdata;

            if (fwd)      dir_fwd <= 1'b1;
            else if (rev) dir_fwd <= 1'b0;
        end
    end
endmodule

// File: rtl/qenc_vel.sv
`timescale 1ns/1ps
module qenc_vel #(
    parameter int TMR_W      = 16,
    parameter int VEL_W      = 16,
    parameter int PERIOD_DEF = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             per_wr,
    input  logic [TMR_W-1:0] per_val,
    output logic [VEL_W-1:0] velocity,
    output logic             expire
);
    logic [TMR_W-1:0] period_q;
    logic [TMR_W-1:0] tmr;
    logic [VEL_W-1:0] acc;
    logic [VEL_W-1:0] acc_inc;

    assign acc_inc = (step && acc != '1) ? acc + 1'b1 : acc;
    assign expire  = (tmr == '0) && !per_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= TMR_W'(PERIOD_DEF);
            tmr      <= TMR_W'(PERIOD_DEF);
            acc      <= '0;
            velocity <= '0;
        end else if (per_wr) begin
            period_q <= per_val;
            tmr      <= per_val;
            acc      <= '0;
        end else if (tmr == '0) begin
            tmr      <= period_q;
            velocity <= acc_inc;
            acc      <= '0;
        end else begin
            tmr <= tmr - 1'b1;
            acc <= acc_inc;
        end
    end
endmodule

// File: rtl/qenc_irq.sv
`timescale 1ns/1ps
module qenc_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr_wr,
    input  logic         mask_wr,
    input  logic [N-1:0] wbits,
    output logic [N-1:0] status,
    output logic         irq
);
    logic [N-1:0] mask_q;
    logic [N-1:0] clr_v;

    assign clr_v = clr_wr ? wbits : '0;
    assign irq   = |(status & mask_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
            mask_q <= '0;
        end else begin
            status <= (status & ~clr_v) | set;
            if (mask_wr) mask_q <= wbits;
        end
    end
endmodule

// File: rtl/qenc_core.sv
`timescale 1ns/1ps
module qenc_core
    import qenc_pkg::*;
#(
    parameter int POS_W      = 16,
    parameter int VEL_W      = 16,
    parameter int TMR_W      = 16,
    parameter int REG_W      = 16,
    parameter int SYNC_STG   = 2,
    parameter int PERIOD_DEF = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ph_a,
    input  logic              ph_b,
    input  logic              idx_in,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [POS_W-1:0]  position,
    output logic [VEL_W-1:0]  velocity,
    output logic              dir_fwd,
    output logic [IRQ_N-1:0]  irq_status,
    output logic              irq
);
    logic [2:0]       syn;
    logic             idx_q;
    logic             idx_rise;
    logic             fwd_step;
    logic             rev_step;
    logic             qerr_pulse;
    logic             dir_chg;
    logic             win_expire;
    logic [POS_W-1:0] max_q;
    logic [IRQ_N-1:0] ev_set;

    logic wr_pos, wr_max, wr_per, wr_mask, wr_clr;
    assign wr_pos  = reg_wr && (reg_addr == A_POS);
    assign wr_max  = reg_wr && (reg_addr == A_MAX);
    assign wr_per  = reg_wr && (reg_addr == A_PER);
    assign wr_mask = reg_wr && (reg_addr == A_MASK);
    assign wr_clr  = reg_wr && (reg_addr == A_CLR);

    qenc_sync #(.W(3), .STAGES(SYNC_STG)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({idx_in, ph_a, ph_b}),
        .dout (syn)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= 1'b0;
        else        idx_q <= syn[2];
    end
    assign idx_rise = syn[2] && !idx_q;

    qenc_decode u_dec (
        .clk  (clk),
        .rst_n(rst_n),
        .ab   (syn[1:0]),
        .fwd  (fwd_step),
        .rev  (rev_step),
        .err  (qerr_pulse)
    );

    qenc_pos #(.W(POS_W)) u_pos (
        .clk    (clk),
        .rst_n  (rst_n),
        .fwd    (fwd_step),
        .rev    (rev_step),
        .pos_wr (wr_pos),
        .max_wr (wr_max),
        .wdata  (reg_wdata[POS_W-1:0]),
        .pos    (position),
        .max_q  (max_q),
        .dir_fwd(dir_fwd),
        .dir_chg(dir_chg)
    );

    qenc_vel #(.TMR_W(TMR_W), .VEL_W(VEL_W), .PERIOD_DEF(PERIOD_DEF)) u_vel (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (fwd_step || rev_step),
        .per_wr  (wr_per),
        .per_val (reg_wdata[TMR_W-1:0]),
        .velocity(velocity),
        .expire  (win_expire)
    );

    always_comb begin
        ev_set           = '0;
        ev_set[IRQ_IDX]  = idx_rise;
        ev_set[IRQ_WIN]  = win_expire;
        ev_set[IRQ_DIR]  = dir_chg;
        ev_set[IRQ_QERR] = qerr_pulse;
    end

    qenc_irq #(.N(IRQ_N)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (ev_set),
        .clr_wr (wr_clr),
        .mask_wr(wr_mask),
        .wbits  (reg_wdata[IRQ_N-1:0]),
        .status (irq_status),
        .irq    (irq)
    );
endmodule

// File: rtl/qenc_chk.sv
`timescale 1ns/1ps
module qenc_chk
    import qenc_pkg::*;
#(
    parameter int POS_W = 16,
    parameter int REG_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic              fwd_step,
    input logic              rev_step,
    input logic              qerr_pulse,
    input logic              win_expire,
    input logic [POS_W-1:0]  position,
    input logic [POS_W-1:0]  max_q,
    input logic              dir_fwd,
    input logic [IRQ_N-1:0]  irq_status
);
    logic             pos_wr;
    logic [IRQ_N-1:0] clr_mask;
    assign pos_wr   = reg_wr && (reg_addr == A_POS);
    assign clr_mask = (reg_wr && reg_addr == A_CLR) ? reg_wdata[IRQ_N-1:0] : '0;

    // R2
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fwd_step, rev_step, qerr_pulse}));

    // R3
    fwd_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_step && position == max_q && !pos_wr) |=> (position == '0));

    // R4
    rev_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rev_step && position == '0 && !pos_wr) |=> (position == $past(max_q)));

    // R5
    qerr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qerr_pulse && !pos_wr) |=> ($stable(position) && $stable(dir_fwd) && irq_status[IRQ_QERR]));

    // R6
    reversal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rev_step && dir_fwd) |=> (!dir_fwd && irq_status[IRQ_DIR]));

    // R8
    win_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_expire |=> irq_status[IRQ_WIN]);

    // R9
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_status) |=> (($past(irq_status) & ~$past(clr_mask) & ~irq_status) == '0));
endmodule

bind qenc_core qenc_chk #(.POS_W(POS_W), .REG_W(REG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .fwd_step  (fwd_step),
    .rev_step  (rev_step),
    .qerr_pulse(qerr_pulse),
    .win_expire(win_expire),
    .position  (position),
    .max_q     (max_q),
    .dir_fwd   (dir_fwd),
    .irq_status(irq_status)
);

// File: tb/tb_qenc_core.sv
`timescale 1ns/1ps
module tb_qenc_core;
    import qenc_pkg::*;
    localparam int W = 16;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             ph_a = 1'b0, ph_b = 1'b0, idx_in = 1'b0;
    logic             reg_wr = 1'b0;
    logic [2:0]       reg_addr = '0;
    logic [W-1:0]     reg_wdata = '0;
    logic [W-1:0]     position, velocity;
    logic             dir_fwd, irq;
    logic [3:0]       irq_status;

    qenc_core dut (
        .clk(clk), .rst_n(rst_n), .ph_a(ph_a), .ph_b(ph_b), .idx_in(idx_in),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .position(position), .velocity(velocity), .dir_fwd(dir_fwd),
        .irq_status(irq_status), .irq(irq)
    );

    typedef struct packed {
        logic [W-1:0] pos;
        logic         dir;
        logic [7:0]   req;
    } exp_t;
    exp_t exp_q[$];

    int  vectors = 0;
    int  miscompares = 0;
    bit  done = 1'b0;

    logic [1:0]   cur_ab = 2'b00;
    logic [W-1:0] m_pos = '0;
    logic [W-1:0] m_max = '1;
    logic         m_dir = 1'b1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] nxt_f(input logic [1:0] x);
        case (x)
            2'b00:   return 2'b10;
            2'b10:   return 2'b11;
            2'b11:   return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [1:0] nxt_r(input logic [1:0] x);
        case (x)
            2'b00:   return 2'b01;
            2'b01:   return 2'b11;
            2'b11:   return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // driver: kind 0 forward, 1 reverse, 2 both phases flip
    task automatic step(input int kind);
        int r;
        @(negedge clk);
        r = 2;
        if (kind == 0) begin
            cur_ab = nxt_f(cur_ab);
            if (m_pos == m_max) r = 3;
            m_pos = (m_pos == m_max) ? '0 : m_pos + 1'b1;
            m_dir = 1'b1;
        end else if (kind == 1) begin
            cur_ab = nxt_r(cur_ab);
            if (m_pos == '0) r = 4;
            m_pos = (m_pos == '0) ? m_max : m_pos - 1'b1;
            m_dir = 1'b0;
        end else begin
            cur_ab = ~cur_ab;
            r = 5;
        end
        {ph_a, ph_b} = cur_ab;
        exp_q.push_back('{pos: m_pos, dir: m_dir, req: 8'(r)});
        repeat (8) @(negedge clk);
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
        repeat (6) @(negedge clk);
    endtask

    // monitor: R2 R3 R4 R5 position and direction after each step
    initial begin
        exp_t e;
        forever begin
            wait (exp_q.size() > 0);
            repeat (4) @(negedge clk);
            e = exp_q.pop_front();
            chk(position == e.pos && dir_fwd == e.dir, $sformatf("R%0d", e.req),
                {15'b0, position, dir_fwd}, {15'b0, e.pos, e.dir});
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        bit seen;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(position == 0, "R12 position", 32'(position), 0);
        chk(velocity == 0, "R12 velocity", 32'(velocity), 0);
        chk(dir_fwd == 1'b1, "R12 dir", 32'(dir_fwd), 1);
        chk(irq_status == 0 && irq == 0, "R12 flags", {27'b0, irq, irq_status}, 0);

        wr(A_PER, 16'd1000);

        // R1 synchronizer latency
        @(negedge clk);
        cur_ab = nxt_f(cur_ab);
        {ph_a, ph_b} = cur_ab;
        m_pos = 16'd1;
        repeat (2) @(negedge clk);
        chk(position == 0, "R1 before third edge", 32'(position), 0);
        @(negedge clk);
        chk(position == 1, "R1 third edge", 32'(position), 1);

        // R11 max load; R2/R3 forward run with wrap
        m_max = 16'd11;
        wr(A_MAX, m_max);
        repeat (14) step(0);
        drain();
        chk(irq_status[IRQ_DIR] == 1'b0, "R6 no reversal yet", 32'(irq_status), 0);

        // R4 reverse run with wrap, R6 reversal flag
        repeat (20) step(1);
        drain();
        chk(irq_status[IRQ_DIR] == 1'b1, "R6 reversal flag", 32'(irq_status), 4);
        chk(irq_status[IRQ_QERR] == 1'b0, "R5 no error yet", 32'(irq_status), 0);

        // R5 illegal transition
        step(2);
        drain();
        chk(irq_status[IRQ_QERR] == 1'b1, "R5 error flag", 32'(irq_status), 8);

        // R9 write-one-to-clear keeps other bits
        wr(A_CLR, 16'b1000);
        @(negedge clk);
        chk(irq_status[IRQ_QERR] == 1'b0 && irq_status[IRQ_DIR] == 1'b1, "R9 clear one bit",
            32'(irq_status), 4);

        // R7 index, R10 masking
        chk(irq == 1'b0, "R10 mask zero", 32'(irq), 0);
        @(negedge clk); idx_in = 1'b1;
        repeat (3) @(negedge clk); idx_in = 1'b0;
        repeat (4) @(negedge clk);
        chk(irq_status[IRQ_IDX] == 1'b1, "R7 index flag", 32'(irq_status), 1);
        wr(A_MASK, 16'b0001);
        @(negedge clk);
        chk(irq == 1'b1, "R10 masked index", 32'(irq), 1);
        wr(A_CLR, 16'b0001);
        @(negedge clk);
        chk(irq == 1'b0, "R10 cleared index", 32'(irq), 0);

        // R8 velocity window
        wr(A_PER, 16'd1000);
        wr(A_CLR, 16'b0010);
        repeat (20) step(0);
        drain();
        seen = 1'b0;
        for (int i = 0; i < 1500 && !seen; i++) begin
            @(negedge clk);
            seen = irq_status[IRQ_WIN];
        end
        chk(seen && velocity == 20, "R8 window count", 32'(velocity), 20);
        wr(A_CLR, 16'b0010);
        seen = 1'b0;
        for (int i = 0; i < 1500 && !seen; i++) begin
            @(negedge clk);
            seen = irq_status[IRQ_WIN];
        end
        chk(seen && velocity == 0, "R8 idle window", 32'(velocity), 0);

        // R11 position load
        wr(A_POS, 16'd7);
        @(negedge clk);
        chk(position == 7, "R11 position load", 32'(position), 7);

        finish_run();
    end
endmodule